// File: doc/BRIEF.md
# Index and Stack Pointer Adjust Unit

This block keeps the 16-bit index register and the 16-bit stack pointer of a small 8-bit processor core. It updates either register on the pointer-arithmetic instructions that do not need the general ALU. It takes the raw opcode byte, accumulator B, the instruction's immediate byte and a one-cycle strobe. It decodes the opcode itself, forms a 16-bit addend, and writes the sum back into the selected register on the next clock edge.

The supported operations are these. Accumulator B can be added to the index register or subtracted from it, with B always read as unsigned. An immediate byte, read as signed, can be added to the index register or to the stack pointer. Each register can also be stepped up or down by one. Every result wraps modulo 65536. There is no carry or overflow output, and no condition flag is produced. A strobe that carries any other opcode is ignored, and this includes a register-to-register add of the 16-bit accumulator, which the unit does not provide.

Top module: `xs_adjust_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `x_out` and `s_out` read 0x0000 and `done` is low.
- R2: A strobe with opcode 0x3A sets X to X + B, with B zero-extended to 16 bits, modulo 65536.
- R3: A strobe with opcode 0x3E sets X to X − B, with B zero-extended to 16 bits, modulo 65536.
- R4: A strobe with opcode 0xCF sets X to X + the immediate sign-extended to 16 bits, so bytes 0x80–0xFF subtract 128–1. The result wraps modulo 65536.
- R5: A strobe with opcode 0x8F sets S to S + the immediate sign-extended to 16 bits, modulo 65536.
- R6: A strobe with opcode 0x08 sets X to X + 1, and opcode 0x09 sets X to X − 1. Both wrap, so 0x0000 − 1 gives 0xFFFF.
- R7: A strobe with opcode 0x31 sets S to S + 1, and opcode 0x34 sets S to S − 1. Both wrap.
- R8: Operations that target X leave S unchanged, and operations that target S leave X unchanged.
- R9: `done` is high in exactly the cycle after a strobe with one of the eight opcodes above. In that same cycle the new register value is visible. `done` is low in every other cycle.
- R10: A strobe carrying any opcode outside the eight above leaves X and S unchanged and does not raise `done`.
- R11: Strobes on consecutive cycles are all executed. Each one works on the value written by the one before it.
- R12: With the strobe low, X and S hold and `done` stays low, whatever the opcode, B and immediate inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_stb | input | 1 | Operation strobe, one cycle per instruction |
| op_byte | input | 8 | Raw opcode byte |
| acc_b | input | 8 | Accumulator B, read as unsigned |
| imm_byte | input | 8 | Immediate operand byte, read as signed |
| x_out | output | 16 | Index register value |
| s_out | output | 16 | Stack pointer value |
| done | output | 1 | Completion pulse for a recognised operation |

## Verification
Two things can happen in the same cycle. The `done` pulse and register write of one operation can coincide with the strobe of the next operation. When that happens, the next operation must pick up the value just written and not the stale one. The bench provokes this by holding the strobe high through long sweeps of every recognised opcode against every B and immediate value. It judges each cycle against a running arithmetic model of both registers. Sweeps with gaps between strobes, and sweeps of unrecognised opcodes, confirm that `done` falls after one cycle and that nothing moves without a valid command.

// File: rtl/xs_pkg.sv
package xs_pkg;

  localparam int XS_REG_W  = 16;
  localparam int XS_BYTE_W = 8;

  localparam logic [7:0] OPC_X_ADD_B   = 8'h3A;
  localparam logic [7:0] OPC_X_SUB_B   = 8'h3E;
  localparam logic [7:0] OPC_X_ADD_IMM = 8'hCF;
  localparam logic [7:0] OPC_S_ADD_IMM = 8'h8F;
  localparam logic [7:0] OPC_X_STEP_UP = 8'h08;
  localparam logic [7:0] OPC_X_STEP_DN = 8'h09;
  localparam logic [7:0] OPC_S_STEP_UP = 8'h31;
  localparam logic [7:0] OPC_S_STEP_DN = 8'h34;

  typedef enum logic [2:0] {
    ADDEND_ZERO,
    ADDEND_B_POS,
    ADDEND_B_NEG,
    ADDEND_IMM_SX,
    ADDEND_ONE,
    ADDEND_MINUS_ONE
  } addend_sel_e;

  typedef struct packed {
    logic        legal;
    logic        to_s;
    addend_sel_e sel;
  } xs_dec_t;

endpackage

// File: rtl/xs_rst_sync.sv
module xs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/xs_decode.sv
module xs_decode
  import xs_pkg::*;
(
  input  logic [7:0] op_byte,
  output xs_dec_t    dec
);

  always_comb begin
    dec = '{legal: 1'b1, to_s: 1'b0, sel: ADDEND_ZERO};
    unique case (op_byte)
      OPC_X_ADD_B:   dec.sel = ADDEND_B_POS;
      OPC_X_SUB_B:   dec.sel = ADDEND_B_NEG;
      OPC_X_ADD_IMM: dec.sel = ADDEND_IMM_SX;
      OPC_X_STEP_UP: dec.sel = ADDEND_ONE;
      OPC_X_STEP_DN: dec.sel = ADDEND_MINUS_ONE;
      OPC_S_ADD_IMM: begin dec.sel = ADDEND_IMM_SX;    dec.to_s = 1'b1; end
      OPC_S_STEP_UP: begin dec.sel = ADDEND_ONE;       dec.to_s = 1'b1; end
      OPC_S_STEP_DN: begin dec.sel = ADDEND_MINUS_ONE; dec.to_s = 1'b1; end
      default:       dec.legal = 1'b0;
    endcase
  end

  // R10: an unrecognised opcode must never select a non-zero addend
  always_comb begin
    a_r10_illegal_zero_addend: assert (dec.legal || dec.sel == ADDEND_ZERO);
  end

endmodule

// File: rtl/xs_addend.sv
module xs_addend
  import xs_pkg::*;
#(
  parameter int W  = XS_REG_W,
  parameter int DW = XS_BYTE_W
) (
  input  addend_sel_e     sel,
  input  logic [DW-1:0]   b_val,
  input  logic [DW-1:0]   imm_val,
  output logic [W-1:0]    addend
);

  localparam int EXT = W - DW;

  logic [W-1:0] b_zx;
  logic [W-1:0] imm_sx;
  logic [W-1:0] one_w;

  generate
    if (EXT > 0) begin : g_widen
      assign b_zx   = {{EXT{1'b0}}, b_val};
      assign imm_sx = {{EXT{imm_val[DW-1]}}, imm_val};
    end else begin : g_same
      assign b_zx   = b_val[W-1:0];
      assign imm_sx = imm_val[W-1:0];
    end
  endgenerate

  assign one_w = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (sel)
      ADDEND_B_POS:     addend = b_zx;
      ADDEND_B_NEG:     addend = (~b_zx) + one_w;
      ADDEND_IMM_SX:    addend = imm_sx;
      ADDEND_ONE:       addend = one_w;
      ADDEND_MINUS_ONE: addend = '1;
      default:          addend = '0;
    endcase
  end

endmodule

// File: rtl/xs_adjust_unit.sv
module xs_adjust_unit
  import xs_pkg::*;
#(
  parameter int W  = XS_REG_W,
  parameter int DW = XS_BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_stb,
  input  logic [7:0]    op_byte,
  input  logic [DW-1:0] acc_b,
  input  logic [DW-1:0] imm_byte,
  output logic [W-1:0]  x_out,
  output logic [W-1:0]  s_out,
  output logic          done
);

  localparam int EXT = W - DW;

  logic         rst_s_n;
  xs_dec_t      dec;
  logic [W-1:0] addend;
  logic [W-1:0] base;
  logic [W-1:0] sum;
  logic         exec_en;

  logic [W-1:0] x_q, x_d;
  logic [W-1:0] s_q, s_d;
  logic         done_q, done_d;
  logic         chk_armed_q;

  xs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  xs_decode u_decode (
    .op_byte (op_byte),
    .dec     (dec)
  );

  xs_addend #(.W(W), .DW(DW)) u_addend (
    .sel     (dec.sel),
    .b_val   (acc_b),
    .imm_val (imm_byte),
    .addend  (addend)
  );

  // one shared adder; the base register is picked before it
  assign exec_en = op_stb && dec.legal;
  assign base    = dec.to_s ? s_q : x_q;
  assign sum     = base + addend;

  always_comb begin
    x_d    = x_q;
    s_d    = s_q;
    done_d = exec_en;
    if (exec_en) begin
      if (dec.to_s) s_d = sum;
      else          x_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      x_q    <= '0;
      s_q    <= '0;
      done_q <= 1'b0;
    end else begin
      x_q    <= x_d;
      s_q    <= s_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) chk_armed_q <= 1'b0;
    else          chk_armed_q <= 1'b1;
  end

  assign x_out = x_q;
  assign s_out = s_q;
  assign done  = done_q;

  // R2: unsigned B added to X
  a_r2_add_b: assert property (@(posedge clk) disable iff (!rst_s_n)
    (chk_armed_q && op_stb && op_byte == OPC_X_ADD_B)
      |=> x_out == W'($past(x_out) + {{EXT{1'b0}}, $past(acc_b)}));

  // R3: unsigned B subtracted from X
  a_r3_sub_b: assert property (@(posedge clk) disable iff (!rst_s_n)
    (chk_armed_q && op_stb && op_byte == OPC_X_SUB_B)
      |=> x_out == W'($past(x_out) - {{EXT{1'b0}}, $past(acc_b)}));

  // R4: signed immediate added to X
  a_r4_x_imm: assert property (@(posedge clk) disable iff (!rst_s_n)
    (chk_armed_q && op_stb && op_byte == OPC_X_ADD_IMM)
      |=> x_out == W'($past(x_out) + {{EXT{$past(imm_byte[DW-1])}}, $past(imm_byte)}));

  // R5: signed immediate added to S
  a_r5_s_imm: assert property (@(posedge clk) disable iff (!rst_s_n)
    (chk_armed_q && op_stb && op_byte == OPC_S_ADD_IMM)
      |=> s_out == W'($past(s_out) + {{EXT{$past(imm_byte[DW-1])}}, $past(imm_byte)}));

  // R8: X-targeted work keeps S, S-targeted work keeps X
  a_r8_s_kept: assert property (@(posedge clk) disable iff (!rst_s_n)
    (chk_armed_q && exec_en && !dec.to_s) |=> $stable(s_out));
  a_r8_x_kept: assert property (@(posedge clk) disable iff (!rst_s_n)
    (chk_armed_q && exec_en && dec.to_s) |=> $stable(x_out));

  // R9: done only follows a strobe
  a_r9_done_cause: assert property (@(posedge clk) disable iff (!rst_s_n)
    (chk_armed_q && done) |-> $past(op_stb));

  // R10: unknown opcode has no effect
  a_r10_unknown: assert property (@(posedge clk) disable iff (!rst_s_n)
    (chk_armed_q && op_stb && !dec.legal)
      |=> (!done && $stable(x_out) && $stable(s_out)));

  // R12: idle cycles hold both registers
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (chk_armed_q && !op_stb)
      |=> (!done && $stable(x_out) && $stable(s_out)));

endmodule

// File: tb/xs_adjust_unit_tb.sv
module xs_adjust_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        op_stb;
  logic [7:0]  op_byte;
  logic [7:0]  acc_b;
  logic [7:0]  imm_byte;
  logic [15:0] x_out;
  logic [15:0] s_out;
  logic        done;

  int checks;
  int errors;

  logic [15:0] exp_x;
  logic [15:0] exp_s;
  logic        exp_done;

  xs_adjust_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_stb   (op_stb),
    .op_byte  (op_byte),
    .acc_b    (acc_b),
    .imm_byte (imm_byte),
    .x_out    (x_out),
    .s_out    (s_out),
    .done     (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit known_op(input logic [7:0] o);
    return (o == 8'h3A) || (o == 8'h3E) || (o == 8'hCF) || (o == 8'h8F) ||
           (o == 8'h08) || (o == 8'h09) || (o == 8'h31) || (o == 8'h34);
  endfunction

  function automatic string tag_of(input logic [7:0] o, input logic stb);
    if (!stb) return "R12";
    case (o)
      8'h3A: return "R2";
      8'h3E: return "R3";
      8'hCF: return "R4";
      8'h8F: return "R5";
      8'h08, 8'h09: return "R6";
      8'h31, 8'h34: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic check16(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check1(input string tag, input string what,
                        input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // one cycle of stimulus, then compare after the edge
  task automatic step(input logic [7:0] opc, input logic stb,
                      input logic [7:0] b, input logic [7:0] im, input string extra);
    string t;
    logic [15:0] sx;
    @(negedge clk);
    op_stb   = stb;
    op_byte  = opc;
    acc_b    = b;
    imm_byte = im;
    sx = {{8{im[7]}}, im};
    exp_done = stb && known_op(opc);
    if (exp_done) begin
      case (opc)
        8'h3A: exp_x = exp_x + {8'h00, b};
        8'h3E: exp_x = exp_x - {8'h00, b};
        8'hCF: exp_x = exp_x + sx;
        8'h8F: exp_s = exp_s + sx;
        8'h08: exp_x = exp_x + 16'd1;
        8'h09: exp_x = exp_x - 16'd1;
        8'h31: exp_s = exp_s + 16'd1;
        8'h34: exp_s = exp_s - 16'd1;
        default: ;
      endcase
    end
    t = {tag_of(opc, stb), extra};
    @(posedge clk);
    #1;
    check16(t, "x_out (R8 for S ops)", x_out, exp_x);
    check16(t, "s_out (R8 for X ops)", s_out, exp_s);
    check1({t, " R9"}, "done", done, exp_done);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    exp_x = 16'h0000;
    exp_s = 16'h0000;
    exp_done = 1'b0;
    rst_n = 1'b0;
    op_stb = 1'b0;
    op_byte = 8'h00;
    acc_b = 8'h00;
    imm_byte = 8'h00;

    // R1: reset state, with a strobe presented during reset
    repeat (3) @(negedge clk);
    op_stb = 1'b1;
    op_byte = 8'h08;
    @(negedge clk);
    check16("R1", "x_out in reset", x_out, 16'h0000);
    check16("R1", "s_out in reset", s_out, 16'h0000);
    check1("R1", "done in reset", done, 1'b0);
    op_stb = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check16("R1", "x_out after release", x_out, 16'h0000);
    check16("R1", "s_out after release", s_out, 16'h0000);
    check1("R1", "done after release", done, 1'b0);

    // gapped operations: wrap corners, one-cycle done pulse
    step(8'h09, 1'b1, 8'h00, 8'h00, " wrap-dec");  // R6 0000-1
    step(8'h00, 1'b0, 8'h00, 8'h00, " gap");
    step(8'h08, 1'b1, 8'h00, 8'h00, " wrap-inc");  // R6 FFFF+1
    step(8'h00, 1'b0, 8'h00, 8'h00, " gap");
    step(8'h34, 1'b1, 8'h00, 8'h00, " wrap-dec");  // R7
    step(8'h00, 1'b0, 8'h00, 8'h00, " gap");
    step(8'h31, 1'b1, 8'h00, 8'h00, " wrap-inc");  // R7
    step(8'h00, 1'b0, 8'h00, 8'h00, " gap");
    step(8'hCF, 1'b1, 8'h00, 8'h80, " min-imm");   // R4 -128 wrap
    step(8'hCF, 1'b1, 8'h00, 8'h7F, " max-imm");   // R4 +127
    step(8'h3A, 1'b1, 8'h80, 8'hFF, " b-unsigned");// R2 +128 not -128
    step(8'h3E, 1'b1, 8'hFF, 8'h00, " b-unsigned");// R3 -255
    step(8'h8F, 1'b1, 8'hFF, 8'h80, " min-imm");   // R5
    step(8'h8F, 1'b1, 8'h00, 8'h7F, " max-imm");   // R5
    step(8'h00, 1'b0, 8'hAA, 8'h55, " gap");

    // R11: back-to-back sweep of every known opcode against every byte
    for (int k = 0; k < 8; k++) begin
      logic [7:0] opc;
      case (k)
        0: opc = 8'h3A; 1: opc = 8'h3E; 2: opc = 8'hCF; 3: opc = 8'h8F;
        4: opc = 8'h08; 5: opc = 8'h09; 6: opc = 8'h31; default: opc = 8'h34;
      endcase
      for (int v = 0; v < 256; v++) begin
        step(opc, 1'b1, v[7:0], 8'(v * 37 + 11), " R11 chained");
      end
    end

    // R10: every unknown opcode, strobed back-to-back
    for (int o = 0; o < 256; o++) begin
      if (!known_op(o[7:0])) step(o[7:0], 1'b1, 8'(o + 3), 8'(o ^ 8'hC3), "");
    end

    // R12: strobe low while every opcode value is shown
    for (int o = 0; o < 256; o++) begin
      step(o[7:0], 1'b0, 8'(o * 5), 8'(~o), "");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule